// File: doc/BRIEF.md
# Multi-Lane Serial Flash Read Front-End

This block is the device side of a serial flash slave, limited to reads. Once chip select goes low it collects an instruction byte, a 3-byte address and a number of dummy clocks, then streams read data back. The host can use one, two or four data lines. A protocol setting picks the lane count for the instruction. In single-line mode each read opcode then picks its own lane count for the address and data phases. In the dual and quad settings every phase uses the full set of lines.

Data bytes come from an external storage interface through a request/data handshake. Each request carries the byte address. The block asks for each byte one byte ahead of the shift-out, so the next byte is ready before its first bit is due. The address steps up after every byte.

An execute-in-place setting skips the instruction phase altogether. The next transfer begins with the address, followed by a programmable dummy count and then data. The serial clock, chip select and data lines are sampled with a faster system clock. The serial clock must stay at each level for at least two system clock cycles.

Top module: `sflash_read_frontend`

## Requirements
- R1: After reset, and one system clock after chip select is high, `dq_oe` is 0 and `fetch_req` is low.
- R2: The instruction byte is taken most significant bit first, one group of bits per rising serial clock edge. The lane setting is `proto_mode`: 0 means single line, `dq_in[0]`, 8 clocks. 1 means dual, `dq_in[1]` more significant, 4 clocks. 2 means quad, `dq_in[3]` most significant, 2 clocks.
- R3: In single-line mode the accepted opcodes and their (address lanes, data lanes) are: 0x03 (1,1), 0x0B (1,1), 0x3B (1,2), 0xBB (2,2), 0x6B (1,4), 0xEB (4,4) and 0x05 (no address, 1).
- R4: In dual or quad mode, every accepted opcode uses 2 or 4 lanes for its address and data phases.
- R5: The dummy count is zero for 0x03 and 0x05 and FAST_DUMMY (8) serial clocks for the other read opcodes. The 24-bit address is shifted most significant bit first.
- R6: Output bits change only after a falling serial clock edge and are shifted most significant bit first. One lane drives `dq_out[1]`. Two lanes drive `dq_out[1:0]`, bit 1 first in order. Four lanes drive `dq_out[3:0]`, bit 3 first in order. The first bit is valid before the first rising edge after the last address or dummy clock.
- R7: `dq_oe` is nonzero only during the data phase. It equals 0010, 0011 or 1111 for one, two or four data lanes.
- R8: At the end of the address, `fetch_req` pulses for one system clock with `fetch_addr` set to the received address. Each byte loaded into the shifter raises a further pulse with the address plus one, wrapping at 24 bits. `fetch_data` is taken at the next byte load.
- R9: With `xip_en` high, a transfer starts directly with the address on the `proto_mode` lanes. It then waits `xip_dummy` serial clocks, which may be zero, before data on the same lanes.
- R10: Chip select high at any bit ends the transfer, and the next transfer decodes from its first bit.
- R11: An unrecognised opcode produces no output enable and no fetch request until chip select goes high.
- R12: Opcode 0x05 returns `reg_value` in every data byte, with no address phase and no fetch request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| proto_mode | input | 2 | 0 single line, 1 dual, 2 quad, 3 treated as single |
| xip_en | input | 1 | Execute-in-place: start transfers at the address phase |
| xip_dummy | input | 4 | Dummy clocks used in execute-in-place reads |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idles low |
| dq_in | input | 4 | Serial data input lines |
| dq_out | output | 4 | Serial data output lines |
| dq_oe | output | 4 | Per-line output enable |
| fetch_req | output | 1 | One-cycle request for a storage byte |
| fetch_addr | output | 24 | Address of the requested byte |
| fetch_data | input | 8 | Requested byte, valid from the cycle after the request |
| reg_value | input | 8 | Register value returned by opcode 0x05 |

## Verification
A rising serial clock edge takes effect on the first system clock edge after it, so `fetch_req` for the start address rises one system clock after the last address bit's rising edge. A new output group appears on `dq_out` on the first system clock edge after the falling serial clock edge. The bench holds each serial clock level for two system clocks. It reads `dq_out` and `dq_oe` at the end of the low half, just before it raises the serial clock, which is at least one cycle after the output can change. It reads `dq_oe` again one system clock after chip select rises, where R1 and R10 say it must be zero.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
    typedef enum logic [1:0] {LN1 = 2'd0, LN2 = 2'd1, LN4 = 2'd2} lane_e;
    typedef enum logic [2:0] {ST_OPC, ST_ADDR, ST_DUMMY, ST_DATA, ST_IGN} state_e;

    function automatic lane_e proto_lane(input logic [1:0] mode);
        case (mode)
            2'd1:    return LN2;
            2'd2:    return LN4;
            default: return LN1;
        endcase
    endfunction

    function automatic logic [2:0] lane_bits(input lane_e ln);
        case (ln)
            LN2:     return 3'd2;
            LN4:     return 3'd4;
            default: return 3'd1;
        endcase
    endfunction
endpackage

// File: rtl/sfe_edge.sv
module sfe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic rise,
    output logic fall
);
    logic sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    assign rise = sck & ~sck_q;
    assign fall = ~sck & sck_q;
endmodule

// File: rtl/sfe_opdecode.sv
module sfe_opdecode
    import sfe_pkg::*;
#(
    parameter int FAST_DUMMY = 8,
    parameter int DUM_W      = 4
) (
    input  logic [7:0]       opcode,
    input  lane_e            plane,
    output logic             valid,
    output logic             is_reg,
    output lane_e            aln,
    output lane_e            dln,
    output logic [DUM_W-1:0] dummy
);
    always_comb begin
        valid  = 1'b1;
        is_reg = 1'b0;
        aln    = plane;
        dln    = plane;
        dummy  = DUM_W'(FAST_DUMMY);
        case (opcode)
            8'h03: dummy = '0;
            8'h0B: ;
            8'h05: begin is_reg = 1'b1; dummy = '0; end
            8'h3B: if (plane == LN1) dln = LN2;
            8'hBB: if (plane == LN1) begin aln = LN2; dln = LN2; end
            8'h6B: if (plane == LN1) dln = LN4;
            8'hEB: if (plane == LN1) begin aln = LN4; dln = LN4; end
            default: valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/sfe_lane_in.sv
module sfe_lane_in
    import sfe_pkg::*;
(
    input  lane_e       ln,
    input  logic [3:0]  dq,
    output logic [3:0]  bits,
    output logic [2:0]  nbits
);
    always_comb begin
        case (ln)
            LN2:     bits = {2'b00, dq[1:0]};
            LN4:     bits = dq;
            default: bits = {3'b000, dq[0]};
        endcase
        nbits = lane_bits(ln);
    end
endmodule

// File: rtl/sfe_lane_out.sv
module sfe_lane_out
    import sfe_pkg::*;
(
    input  lane_e       ln,
    input  logic [7:0]  data,
    output logic [3:0]  pins,
    output logic [3:0]  mask,
    output logic [2:0]  nbits
);
    always_comb begin
        case (ln)
            LN2:     begin pins = {2'b00, data[7:6]};       mask = 4'b0011; end
            LN4:     begin pins = data[7:4];                mask = 4'b1111; end
            default: begin pins = {2'b00, data[7], 1'b0};   mask = 4'b0010; end
        endcase
        nbits = lane_bits(ln);
    end
endmodule

// File: rtl/sflash_read_frontend.sv
module sflash_read_frontend
    import sfe_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int FAST_DUMMY = 8,
    parameter int XIPD_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        proto_mode,
    input  logic              xip_en,
    input  logic [XIPD_W-1:0] xip_dummy,
    input  logic              cs_n,
    input  logic              sck,
    input  logic [3:0]        dq_in,
    output logic [3:0]        dq_out,
    output logic [3:0]        dq_oe,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic [7:0]        fetch_data,
    input  logic [7:0]        reg_value
);
    localparam int CNT_W  = $clog2(ADDR_W + 1);
    localparam int FD_W   = $clog2(FAST_DUMMY + 1);
    localparam int DUM_W  = (FD_W > XIPD_W) ? FD_W : XIPD_W;
    localparam int OP_W   = 8;

    typedef struct packed {
        state_e             st;
        logic [CNT_W-1:0]   cnt;
        logic [ADDR_W-1:0]  sr;
        lane_e              aln;
        lane_e              dln;
        logic [DUM_W-1:0]   dum;
        logic               isreg;
        logic [7:0]         obyte;
        logic [2:0]         ocnt;
        logic [3:0]         dout;
        logic [3:0]         oe;
        logic               freq;
        logic [ADDR_W-1:0]  faddr;
    } core_t;

    core_t r_d, r_q;

    logic              rise, fall;
    lane_e             plane, in_ln;
    logic [3:0]        in_bits;
    logic [2:0]        n_in, n_out;
    logic [ADDR_W-1:0] sr_shift;
    logic [CNT_W-1:0]  cnt_nxt;
    logic              dec_valid, dec_reg;
    lane_e             dec_aln, dec_dln;
    logic [DUM_W-1:0]  dec_dum;
    logic [7:0]        cur_byte;
    logic [3:0]        out_pins, out_mask;

    sfe_edge u_edge (.clk(clk), .rst_n(rst_n), .sck(sck), .rise(rise), .fall(fall));

    assign plane = proto_lane(proto_mode);
    assign in_ln = (r_q.st == ST_OPC) ? plane : r_q.aln;

    sfe_lane_in u_lin (.ln(in_ln), .dq(dq_in), .bits(in_bits), .nbits(n_in));

    assign sr_shift = (r_q.sr << n_in) | ADDR_W'(in_bits);
    assign cnt_nxt  = r_q.cnt + CNT_W'(n_in);

    sfe_opdecode #(.FAST_DUMMY(FAST_DUMMY), .DUM_W(DUM_W)) u_dec (
        .opcode(sr_shift[OP_W-1:0]), .plane(plane), .valid(dec_valid),
        .is_reg(dec_reg), .aln(dec_aln), .dln(dec_dln), .dummy(dec_dum)
    );

    assign cur_byte = (r_q.ocnt != 3'd0) ? r_q.obyte :
                      (r_q.isreg ? reg_value : fetch_data);

    sfe_lane_out u_lout (.ln(r_q.dln), .data(cur_byte), .pins(out_pins),
                         .mask(out_mask), .nbits(n_out));

    always_comb begin
        r_d      = r_q;
        r_d.freq = 1'b0;
        if (cs_n) begin
            r_d.st    = xip_en ? ST_ADDR : ST_OPC;
            r_d.cnt   = '0;
            r_d.sr    = '0;
            r_d.aln   = plane;
            r_d.dln   = plane;
            r_d.dum   = DUM_W'(xip_dummy);
            r_d.isreg = 1'b0;
            r_d.ocnt  = '0;
            r_d.oe    = '0;
        end else if (rise) begin
            case (r_q.st)
                ST_OPC: begin
                    r_d.sr  = sr_shift;
                    r_d.cnt = cnt_nxt;
                    if (cnt_nxt == CNT_W'(OP_W)) begin
                        r_d.cnt   = '0;
                        r_d.aln   = dec_aln;
                        r_d.dln   = dec_dln;
                        r_d.dum   = dec_dum;
                        r_d.isreg = dec_reg;
                        r_d.st    = !dec_valid ? ST_IGN : (dec_reg ? ST_DATA : ST_ADDR);
                    end
                end
                ST_ADDR: begin
                    r_d.sr  = sr_shift;
                    r_d.cnt = cnt_nxt;
                    if (cnt_nxt == CNT_W'(ADDR_W)) begin
                        r_d.cnt   = '0;
                        r_d.faddr = sr_shift;
                        r_d.freq  = 1'b1;
                        r_d.st    = (r_q.dum == '0) ? ST_DATA : ST_DUMMY;
                    end
                end
                ST_DUMMY: begin
                    r_d.dum = r_q.dum - 1'b1;
                    if (r_q.dum == DUM_W'(1)) r_d.st = ST_DATA;
                end
                default: ;
            endcase
        end else if (fall && r_q.st == ST_DATA) begin
            r_d.dout  = out_pins;
            r_d.oe    = out_mask;
            r_d.obyte = cur_byte << n_out;
            r_d.ocnt  = r_q.ocnt + n_out;
            if (r_q.ocnt == 3'd0 && !r_q.isreg) begin
                r_d.freq  = 1'b1;
                r_d.faddr = r_q.faddr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_OPC;
            r_q.aln <= LN1;
            r_q.dln <= LN1;
        end else begin
            r_q <= r_d;
        end
    end

    assign dq_out     = r_q.dout;
    assign dq_oe      = r_q.oe;
    assign fetch_req  = r_q.freq;
    assign fetch_addr = r_q.faddr;

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !fetch_req); // R1
    AST_CS_DROPS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (dq_oe == 4'b0000)); // R10
    AST_OE_LANE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe == 4'b0000) || (dq_oe == 4'b0010) || (dq_oe == 4'b0011) || (dq_oe == 4'b1111)); // R7
    AST_OE_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe != 4'b0000) |-> (r_q.st == ST_DATA)); // R7
    AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_out != $past(dq_out)) |-> $past(fall)); // R6
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> !fetch_req); // R8
endmodule

// File: tb/sim_sflash_read_frontend.sv
module sim_sflash_read_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  proto_mode = 2'd0;
    logic        xip_en = 1'b0;
    logic [3:0]  xip_dummy = 4'd0;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic [3:0]  dq_in = 4'd0;
    logic [3:0]  dq_out, dq_oe;
    logic        fetch_req;
    logic [23:0] fetch_addr;
    logic [7:0]  fetch_data = 8'd0;
    logic [7:0]  reg_value = 8'hC6;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sflash_read_frontend u0 (
        .clk(clk), .rst_n(rst_n), .proto_mode(proto_mode), .xip_en(xip_en),
        .xip_dummy(xip_dummy), .cs_n(cs_n), .sck(sck), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .fetch_data(fetch_data), .reg_value(reg_value)
    );

    function automatic logic [7:0] mem_f(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    int          req_total = 0;
    logic [23:0] req_log [256];
    always @(posedge clk) if (fetch_req) begin
        req_log[req_total % 256] <= fetch_addr;
        req_total <= req_total + 1;
        fetch_data <= mem_f(fetch_addr);
    end

    typedef struct packed {
        logic [1:0]  proto;
        logic        xip;
        logic [3:0]  xipd;
        logic [7:0]  op;
        logic [23:0] addr;
        logic [3:0]  nbytes;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 4'd0, 8'h03, 24'h000100, 4'd3},
        '{2'd0, 1'b0, 4'd0, 8'h0B, 24'h123456, 4'd2},
        '{2'd0, 1'b0, 4'd0, 8'h3B, 24'h00FFFE, 4'd3},
        '{2'd0, 1'b0, 4'd0, 8'hBB, 24'hABCDEF, 4'd2},
        '{2'd0, 1'b0, 4'd0, 8'h6B, 24'h345678, 4'd3},
        '{2'd0, 1'b0, 4'd0, 8'hEB, 24'hFFFFFF, 4'd2},
        '{2'd1, 1'b0, 4'd0, 8'h0B, 24'h222222, 4'd2},
        '{2'd1, 1'b0, 4'd0, 8'h03, 24'h0F0F0F, 4'd2},
        '{2'd2, 1'b0, 4'd0, 8'hEB, 24'h777777, 4'd3},
        '{2'd2, 1'b0, 4'd0, 8'h03, 24'h000001, 4'd2},
        '{2'd2, 1'b1, 4'd6, 8'h00, 24'h456789, 4'd2},
        '{2'd1, 1'b1, 4'd0, 8'h00, 24'hC0FFEE, 4'd2},
        '{2'd0, 1'b0, 4'd0, 8'h05, 24'h000000, 4'd2}
    };

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // Lane plan taken from R2, R3, R4, R5, R9 and R12
    task automatic plan(input vec_t v, output int opl, output int al, output int dl,
                        output int dum, output bit isreg);
        int pl;
        pl = (v.proto == 2'd1) ? 2 : (v.proto == 2'd2) ? 4 : 1;
        opl = pl; al = pl; dl = pl; isreg = 0;
        dum = (v.op == 8'h03 || v.op == 8'h05) ? 0 : 8;
        if (v.op == 8'h05) isreg = 1;
        if (pl == 1) begin
            case (v.op)
                8'h3B: dl = 2;
                8'hBB: begin al = 2; dl = 2; end
                8'h6B: dl = 4;
                8'hEB: begin al = 4; dl = 4; end
                default: ;
            endcase
        end
        if (v.xip) dum = int'(v.xipd);
    endtask

    task automatic cyc(input logic [3:0] d, output logic [3:0] q, output logic [3:0] oe);
        dq_in = d;
        @(negedge clk); @(negedge clk);
        q = dq_out; oe = dq_oe;
        sck = 1'b1;
        @(negedge clk); @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic send(input logic [23:0] val, input int width, input int lanes, inout bit oe_seen);
        logic [23:0] v;
        logic [3:0]  q, oe;
        v = val << (24 - width);
        for (int i = 0; i < width / lanes; i++) begin
            cyc(4'(v[23:20] >> (4 - lanes)), q, oe);
            if (oe != 4'd0) oe_seen = 1;
            v = v << lanes;
        end
    endtask

    function automatic logic [3:0] pick(input logic [3:0] q, input int lanes);
        if (lanes == 1) return {3'b000, q[1]};
        if (lanes == 2) return {2'b00, q[1:0]};
        return q;
    endfunction

    task automatic run(input vec_t v);
        int opl, al, dl, dum, base;
        bit isreg, oe_early, oe_bad;
        logic [3:0] q, oe, mask;
        logic [7:0] b, exp;
        string tag;
        plan(v, opl, al, dl, dum, isreg);
        tag = v.xip ? "R9" : isreg ? "R12" : (v.proto != 2'd0) ? "R2 R4" : "R3";
        mask = (dl == 1) ? 4'b0010 : (dl == 2) ? 4'b0011 : 4'b1111;
        @(negedge clk);
        proto_mode = v.proto; xip_en = v.xip; xip_dummy = v.xipd;
        @(negedge clk); @(negedge clk);
        base = req_total;
        oe_early = 0; oe_bad = 0;
        cs_n = 1'b0;
        if (!v.xip) send({16'd0, v.op}, 8, opl, oe_early);
        if (!isreg) send(v.addr, 24, al, oe_early);
        for (int i = 0; i < dum; i++) begin
            cyc(4'd0, q, oe);
            if (oe != 4'd0) oe_early = 1;
        end
        for (int k = 0; k < int'(v.nbytes); k++) begin
            b = 8'd0;
            for (int c = 0; c < 8 / dl; c++) begin
                cyc(4'd0, q, oe);
                b = (b << dl) | 8'(pick(q, dl));
                if (oe != mask) oe_bad = 1;
            end
            exp = isreg ? reg_value : mem_f(v.addr + 24'(k));
            check(b == exp, {tag, " R5 R6 data byte"}, 32'(b), 32'(exp));
        end
        check(!oe_early && !oe_bad, "R7 output enable", {oe_early, oe_bad}, 0);
        if (isreg) check(req_total == base, "R12 no fetch", req_total - base, 0);
        else check(req_log[base % 256] == v.addr, "R8 first fetch address", 32'(req_log[base % 256]), 32'(v.addr));
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk);
        check(dq_oe == 4'd0 && !fetch_req, "R1 idle after cs", {dq_oe, fetch_req}, 0);
    endtask

    initial begin
        logic [3:0] q, oe;
        bit oe_seen;
        int base;
        vec_t v;
        repeat (3) @(negedge clk);
        check(dq_oe == 4'd0 && !fetch_req, "R1 in reset", {dq_oe, fetch_req}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(dq_oe == 4'd0 && !fetch_req && dq_out == 4'd0, "R1 after reset", {dq_oe, fetch_req, dq_out}, 0);

        for (int i = 0; i < NV; i++) run(VECS[i]);

        // R11: unknown opcode
        proto_mode = 2'd0; xip_en = 1'b0;
        @(negedge clk); @(negedge clk);
        base = req_total; oe_seen = 0;
        cs_n = 1'b0;
        send(24'h000077, 8, 1, oe_seen);
        for (int i = 0; i < 40; i++) begin
            cyc(4'hF, q, oe);
            if (oe != 4'd0) oe_seen = 1;
        end
        check(!oe_seen, "R11 no enable", 32'(oe_seen), 0);
        check(req_total == base, "R11 no fetch", req_total - base, 0);
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk); @(negedge clk);

        // R10: chip select high in the middle of a byte
        base = req_total; oe_seen = 0;
        cs_n = 1'b0;
        send(24'h00000B, 8, 1, oe_seen);
        send(24'h000010, 24, 1, oe_seen);
        for (int i = 0; i < 8; i++) cyc(4'd0, q, oe);
        cyc(4'd0, q, oe);
        check(q[1] == mem_f(24'h000010)[7], "R10 first bit before cut", 32'(q[1]), 32'(mem_f(24'h000010)[7]));
        cyc(4'd0, q, oe);
        check(oe == 4'b0010, "R10 enable before cut", 32'(oe), 32'h2);
        cs_n = 1'b1;
        @(negedge clk);
        check(dq_oe == 4'd0, "R10 enable cleared", 32'(dq_oe), 0);
        @(negedge clk);
        v = '{2'd0, 1'b0, 4'd0, 8'h03, 24'h0000A0, 4'd2};
        run(v);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule